// File: doc/BRIEF.md
# Daisy-Chained LED PWM Refresh Controller

This block keeps a chain of serial-input, 16-output grayscale PWM driver devices refreshed without help from software. It holds 16 × N_DEV twelve-bit brightness levels that a host updates one at a time through a write port carrying an index and a value. The block generates the grayscale counting clock, the output-disable line, the latch-load strobe and a two-wire serial stream (clock and data) that feeds the chain.

Every PWM period counts PERIOD grayscale clocks. At the end of a period the grayscale clock stops and the outputs are disabled. While they stay disabled, the complete frame is shifted into the chain. The shift runs on every period, even when no level has changed, so the dark time is the same in each period. After the shift a single load strobe transfers the frame into the devices. The outputs are then re-enabled and the period timer is started fresh at that moment, so period boundaries never slide against the actual PWM cycle. After reset the block first flushes the chain with zeros and loads them, and only then starts its normal cycle.

Top module: `led_pwm_refresh`

## Requirements
- R1: During and after reset, outs_off_o is 1 and load_o, pwm_clk_o and ser_clk_o are 0. All stored levels are 0, so the first frame delivered carries only zeros (0 = fully off, 0xFFF = fully on).
- R2: After reset, exactly CLR_PER_DEV × N_DEV zero bits (400 by default) are shifted before the first load strobe. That strobe and one frame strobe both come before outs_off_o first falls.
- R3: Between a fall of outs_off_o and its next rise there are exactly PERIOD (4096) rising edges of pwm_clk_o. pwm_clk_o is never high while outs_off_o is high.
- R4: Every dark interval shifts exactly 192 × N_DEV bits (384 by default) followed by exactly one load strobe, also when no level was written.
- R5: Level index = device × 16 + output, where device 0 is nearest the controller. The frame starts with index 16·N_DEV−1 and ends with index 0, 12 bits per level, most significant bit first, so that after a full frame the bit taken in first sits highest.
- R6: Serial mode 0: ser_dat_o changes only while ser_clk_o is low and is stable while ser_clk_o is high. ser_clk_o idles low.
- R7: load_o is high for exactly one system clock and only while outs_off_o is high. Before it, ser_clk_o has been low for at least one clock, and outs_off_o falls at least one clock after it.
- R8: The frame is taken from a snapshot made as the dark interval begins. A write that lands during the shift appears only in the following frame.
- R9: A write whose index is 16 · N_DEV or above changes no level, including the level its low bits would alias to.
- R10: In every period outs_off_o stays low for exactly PERIOD × GS_DIV + 1 system clocks, because the period timer is restarted at each re-enable.
- R11: After reset, every dark interval lasts fewer than PERIOD × GS_DIV / 4 system clocks, so a frame fits well inside one period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Level write strobe |
| wr_idx | input | $clog2(16·N_DEV+1) | Level index (device × 16 + output) |
| wr_val | input | 12 | New level value |
| pwm_clk_o | output | 1 | Grayscale counting clock to the chain |
| outs_off_o | output | 1 | Output disable; high = all outputs dark |
| load_o | output | 1 | One-clock strobe that loads the shifted frame |
| ser_clk_o | output | 1 | Serial clock, idles low |
| ser_dat_o | output | 1 | Serial data, mode 0 |

## Verification
The frame layout is checked with a ramp-like pattern of distinct levels, with the extreme values 0 and 0xFFF placed at the two ends. A misordered device, a reversed bit order or a shifted index shows up as a mismatch at a known position. A frame sent with no writes at all checks that the refresh repeats unchanged. A write timed into the middle of a shift checks that the snapshot holds: it must miss one frame and show up in the next. Out-of-range indices that alias onto valid ones tell a bounds check apart from a truncated address. Period and dark-interval lengths are measured at the pins over several periods to catch drift or a miscounted timer.

// File: rtl/lpr_pkg.sv
package lpr_pkg;
  localparam int LVL_W      = 12;
  localparam int CH_PER_DEV = 16;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_CAPT,
    ST_SHIFT,
    ST_GAP,
    ST_LOAD,
    ST_HOLD,
    ST_RUN
  } seq_state_t;
endpackage

// File: rtl/lpr_level_store.sv
module lpr_level_store
  import lpr_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int IDX_W  = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [LVL_W-1:0]          wr_val,
  input  logic                      capture,
  input  logic [$clog2(NUM_CH)-1:0] rd_idx,
  output logic [LVL_W-1:0]          rd_val
);
  localparam int CH_W = $clog2(NUM_CH);
  localparam logic [IDX_W-1:0] CH_LIM = IDX_W'(NUM_CH);

  logic [LVL_W-1:0]        live_q [NUM_CH];
  logic [NUM_CH*LVL_W-1:0] snap_q;
  logic                    wr_ok;

  assign wr_ok = wr_en && (wr_idx < CH_LIM);

  // live array takes host writes; the snapshot is the frame source
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CH; i++) live_q[i] <= '0;
      snap_q <= '0;
    end else begin
      if (capture) begin
        for (int i = 0; i < NUM_CH; i++) snap_q[i*LVL_W +: LVL_W] <= live_q[i];
      end
      if (wr_ok) live_q[wr_idx[CH_W-1:0]] <= wr_val;
    end
  end

  assign rd_val = snap_q[rd_idx*LVL_W +: LVL_W];

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(snap_q)); // R8
endmodule

// File: rtl/lpr_shifter.sv
module lpr_shifter
  import lpr_pkg::*;
#(
  parameter int NUM_CH   = 32,
  parameter int SCK_HALF = 2,
  parameter int CLR_BITS = 400
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic                      zero_fill,
  output logic [$clog2(NUM_CH)-1:0] rd_idx,
  input  logic [LVL_W-1:0]          rd_val,
  output logic                      busy,
  output logic                      done,
  output logic                      sck_o,
  output logic                      sdo_o
);
  localparam int FRAME_BITS = NUM_CH * LVL_W;
  localparam int MAX_BITS   = (CLR_BITS > FRAME_BITS) ? CLR_BITS : FRAME_BITS;
  localparam int CNT_W      = $clog2(MAX_BITS);
  localparam int CH_W       = $clog2(NUM_CH);
  localparam int BIT_W      = $clog2(LVL_W);
  localparam int HC_W       = $clog2(SCK_HALF);

  logic             busy_q, hi_q, zero_q, sck_q, sdo_q, done_q;
  logic [HC_W-1:0]  hc_q;
  logic [CNT_W-1:0] left_q;
  logic [CH_W-1:0]  ch_q;
  logic [BIT_W-1:0] bit_q;
  logic             half_end, cur_bit;

  assign half_end = (hc_q == HC_W'(SCK_HALF - 1));
  assign cur_bit  = zero_q ? 1'b0 : rd_val[bit_q];
  assign rd_idx   = ch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0; hi_q <= 1'b0; zero_q <= 1'b0;
      sck_q  <= 1'b0; sdo_q <= 1'b0; done_q <= 1'b0;
      hc_q <= '0; left_q <= '0; ch_q <= '0; bit_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        busy_q <= 1'b1;
        hi_q   <= 1'b0;
        hc_q   <= '0;
        sck_q  <= 1'b0;
        zero_q <= zero_fill;
        ch_q   <= CH_W'(NUM_CH - 1);
        bit_q  <= BIT_W'(LVL_W - 1);
        left_q <= zero_fill ? CNT_W'(CLR_BITS - 1) : CNT_W'(FRAME_BITS - 1);
      end else if (busy_q) begin
        // new data one clock into the low half
        if (!hi_q && hc_q == '0) sdo_q <= cur_bit;
        if (half_end) begin
          hc_q <= '0;
          if (!hi_q) begin
            hi_q  <= 1'b1;
            sck_q <= 1'b1;
          end else begin
            hi_q  <= 1'b0;
            sck_q <= 1'b0;
            if (left_q == '0) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              left_q <= left_q - 1'b1;
              if (bit_q == '0) begin
                bit_q <= BIT_W'(LVL_W - 1);
                ch_q  <= ch_q - 1'b1;
              end else begin
                bit_q <= bit_q - 1'b1;
              end
            end
          end
        end else begin
          hc_q <= hc_q + 1'b1;
        end
      end
    end
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign sck_o = sck_q;
  assign sdo_o = sdo_q;

  AST_DATA_STEADY_HI: assert property (@(posedge clk) disable iff (rst)
    sck_q |-> $stable(sdo_q)); // R6
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !sck_q); // R6
endmodule

// File: rtl/lpr_gs_timer.sv
module lpr_gs_timer #(
  parameter int GS_DIV = 2,
  parameter int PERIOD = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic gs_clk_o,
  output logic active_o,
  output logic done_o
);
  localparam int GSH   = GS_DIV / 2;
  localparam int DIV_W = $clog2(GS_DIV);
  localparam int CNT_W = $clog2(PERIOD);

  logic             act_q, gs_q, done_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0; gs_q <= 1'b0; done_q <= 1'b0;
      div_q <= '0; cnt_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!act_q) begin
        gs_q  <= 1'b0;
        div_q <= '0;
        cnt_q <= '0;
        if (start) act_q <= 1'b1;
      end else begin
        gs_q <= (div_q < DIV_W'(GSH));
        if (div_q == DIV_W'(GS_DIV - 1)) begin
          div_q <= '0;
          if (cnt_q == CNT_W'(PERIOD - 1)) begin
            act_q  <= 1'b0;
            done_q <= 1'b1;
            gs_q   <= 1'b0;
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign gs_clk_o = gs_q;
  assign active_o = act_q;
  assign done_o   = done_q;

  AST_GS_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !act_q |=> !gs_q); // R3
endmodule

// File: rtl/led_pwm_refresh.sv
module led_pwm_refresh
  import lpr_pkg::*;
#(
  parameter int N_DEV       = 2,
  parameter int SCK_HALF    = 2,
  parameter int GS_DIV      = 2,
  parameter int PERIOD      = 4096,
  parameter int CLR_PER_DEV = 200
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    wr_en,
  input  logic [$clog2(CH_PER_DEV*N_DEV+1)-1:0]   wr_idx,
  input  logic [LVL_W-1:0]                        wr_val,
  output logic                                    pwm_clk_o,
  output logic                                    outs_off_o,
  output logic                                    load_o,
  output logic                                    ser_clk_o,
  output logic                                    ser_dat_o
);
  localparam int NUM_CH   = CH_PER_DEV * N_DEV;
  localparam int IDX_W    = $clog2(NUM_CH + 1);
  localparam int CH_W     = $clog2(NUM_CH);
  localparam int CLR_BITS = CLR_PER_DEV * N_DEV;
  localparam int FIT_CYC  = PERIOD * GS_DIV / 4;

  seq_state_t        state;
  logic              off_q, load_q, boot_q;
  logic [31:0]       dark_cnt;
  logic              sh_start, sh_zero, sh_busy, sh_done, capture;
  logic              tmr_start, tmr_act, tmr_done;
  logic [CH_W-1:0]   rd_idx;
  logic [LVL_W-1:0]  rd_val;

  assign sh_start  = (state == ST_BOOT) || (state == ST_CAPT);
  assign sh_zero   = (state == ST_BOOT);
  assign capture   = (state == ST_CAPT);
  assign tmr_start = (state == ST_HOLD) && !boot_q;

  lpr_level_store #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
    .capture(capture), .rd_idx(rd_idx), .rd_val(rd_val)
  );

  lpr_shifter #(.NUM_CH(NUM_CH), .SCK_HALF(SCK_HALF), .CLR_BITS(CLR_BITS)) u_shift (
    .clk(clk), .rst(rst), .start(sh_start), .zero_fill(sh_zero),
    .rd_idx(rd_idx), .rd_val(rd_val), .busy(sh_busy), .done(sh_done),
    .sck_o(ser_clk_o), .sdo_o(ser_dat_o)
  );

  lpr_gs_timer #(.GS_DIV(GS_DIV), .PERIOD(PERIOD)) u_timer (
    .clk(clk), .rst(rst), .start(tmr_start),
    .gs_clk_o(pwm_clk_o), .active_o(tmr_act), .done_o(tmr_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_BOOT;
      off_q    <= 1'b1;
      load_q   <= 1'b0;
      boot_q   <= 1'b1;
      dark_cnt <= '0;
    end else begin
      if (state == ST_CAPT) dark_cnt <= '0;
      else if (off_q)       dark_cnt <= dark_cnt + 1'b1;
      case (state)
        ST_BOOT:  state <= ST_SHIFT;
        ST_CAPT:  state <= ST_SHIFT;
        ST_SHIFT: if (sh_done) state <= ST_GAP;
        ST_GAP: begin
          load_q <= 1'b1;
          state  <= ST_LOAD;
        end
        ST_LOAD: begin
          load_q <= 1'b0;
          state  <= ST_HOLD;
        end
        ST_HOLD: begin
          if (boot_q) begin
            boot_q <= 1'b0;
            state  <= ST_CAPT;
          end else begin
            off_q <= 1'b0;
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (tmr_done) begin
            off_q <= 1'b1;
            state <= ST_CAPT;
          end
        end
        default: state <= ST_BOOT;
      endcase
    end
  end

  assign outs_off_o = off_q;
  assign load_o     = load_q;

  AST_LOAD_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    load_q |=> !load_q); // R7
  AST_LOAD_WHILE_DARK: assert property (@(posedge clk) disable iff (rst)
    load_q |-> off_q); // R7
  AST_LOAD_AFTER_SCK: assert property (@(posedge clk) disable iff (rst)
    load_q |-> (!ser_clk_o && !$past(ser_clk_o))); // R7
  AST_LOAD_NOT_SHIFTING: assert property (@(posedge clk) disable iff (rst)
    load_q |-> !sh_busy); // R4
  AST_GS_OFF_DARK: assert property (@(posedge clk) disable iff (rst)
    off_q |-> !pwm_clk_o); // R3
  AST_RUN_TIMED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |-> (tmr_act || tmr_done)); // R10
  AST_FRAME_FITS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT && !boot_q) |-> (dark_cnt < 32'(FIT_CYC))); // R11
endmodule

// File: tb/sim_led_pwm_refresh.sv
module sim_led_pwm_refresh;
  localparam int N_DEV   = 2;
  localparam int NUM_CH  = 16 * N_DEV;
  localparam int IDX_W   = $clog2(NUM_CH + 1);
  localparam int FRAME   = NUM_CH * 12;
  localparam int CLRB    = 200 * N_DEV;
  localparam int PERIOD  = 4096;
  localparam int GS_DIV  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [IDX_W-1:0] wr_idx = '0;
  logic [11:0] wr_val = '0;
  logic pwm_clk_o, outs_off_o, load_o, ser_clk_o, ser_dat_o;

  always #5 clk = ~clk;

  led_pwm_refresh #(.N_DEV(N_DEV), .SCK_HALF(2), .GS_DIV(GS_DIV), .PERIOD(PERIOD),
                    .CLR_PER_DEV(200)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
    .pwm_clk_o(pwm_clk_o), .outs_off_o(outs_off_o), .load_o(load_o),
    .ser_clk_o(ser_clk_o), .ser_dat_o(ser_dat_o)
  );

  int n_chk = 0, n_err = 0;
  bit timeout = 1'b0;
  logic [11:0] expv [NUM_CH];

  // pin-level chain model and timing monitor
  logic [FRAME-1:0] rx_sr = '0, rx_lat = '0;
  int rx_bits = 0, lat_cnt = 0, last_lat_bits = 0, first_lat_bits = -1, lat_at_fall = -1;
  int rise_cnt = 0, fall_cnt = 0, gs_edges = 0, last_gs_edges = 0;
  int low_len = 0, last_low_len = 0, hi_len = 0, last_hi_len = 0;
  int v3 = 0, v6 = 0, v7 = 0;
  logic p_sck = 1'b0, p_dat = 1'b0, p_load = 1'b0, p_off = 1'b1, p_pwm = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (ser_clk_o && !p_sck) begin
        rx_sr = {rx_sr[FRAME-2:0], ser_dat_o};
        rx_bits = rx_bits + 1;
      end
      if (load_o && !p_load) begin
        rx_lat = rx_sr;
        last_lat_bits = rx_bits;
        if (lat_cnt == 0) first_lat_bits = rx_bits;
        lat_cnt = lat_cnt + 1;
        rx_bits = 0;
      end
      if (pwm_clk_o && !p_pwm && !outs_off_o) gs_edges = gs_edges + 1;
      if (outs_off_o && !p_off) begin
        rise_cnt = rise_cnt + 1;
        last_gs_edges = gs_edges;
        last_low_len = low_len;
        hi_len = 1;
      end else if (outs_off_o) hi_len = hi_len + 1;
      if (!outs_off_o && p_off) begin
        if (fall_cnt == 0) lat_at_fall = lat_cnt;
        fall_cnt = fall_cnt + 1;
        last_hi_len = hi_len;
        low_len = 1;
        gs_edges = 0;
        if (p_load) v7 = v7 + 1;
      end else if (!outs_off_o) low_len = low_len + 1;
      if (ser_clk_o && p_sck && ser_dat_o != p_dat) v6 = v6 + 1;
      if (load_o && p_load) v7 = v7 + 1;
      if (load_o && !outs_off_o) v7 = v7 + 1;
      if (load_o && (ser_clk_o || p_sck)) v7 = v7 + 1;
      if (outs_off_o && pwm_clk_o) v3 = v3 + 1;
    end
    p_sck = ser_clk_o; p_dat = ser_dat_o; p_load = load_o;
    p_off = outs_off_o; p_pwm = pwm_clk_o;
  end

  initial begin
    repeat (190000) @(posedge clk);
    timeout = 1'b1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int idx, input int val);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_val = 12'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_load();
    int c = lat_cnt;
    while (lat_cnt == c && !timeout) @(negedge clk);
  endtask

  task automatic wait_rise();
    int c = rise_cnt;
    while (rise_cnt == c && !timeout) @(negedge clk);
  endtask

  task automatic wait_fall();
    int c = fall_cnt;
    while (fall_cnt == c && !timeout) @(negedge clk);
  endtask

  task automatic check_frame(input string req);
    int bad = 0, fi = -1;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rx_lat[12*i +: 12] !== expv[i]) begin
        bad++;
        if (fi < 0) fi = i;
      end
    end
    if (fi < 0) fi = 0;
    check(bad == 0, req, $sformatf("frame level idx %0d", fi),
          int'(rx_lat[12*fi +: 12]), int'(expv[fi]));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(outs_off_o == 1'b1, "R1", "outs_off in reset", int'(outs_off_o), 1);
    check(load_o == 1'b0, "R1", "load in reset", int'(load_o), 0);
    check(pwm_clk_o == 1'b0, "R1", "pwm clk in reset", int'(pwm_clk_o), 0);
    check(ser_clk_o == 1'b0, "R1", "ser clk in reset", int'(ser_clk_o), 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_boot();
    wait_fall();
    check(first_lat_bits == CLRB, "R2", "zero bits before first load", first_lat_bits, CLRB);
    check(lat_at_fall == 2, "R2", "loads before first enable", lat_at_fall, 2);
    check_frame("R1");
  endtask

  task automatic t_period();
    wait_rise();
    check(last_gs_edges == PERIOD, "R3", "pwm clk edges per period", last_gs_edges, PERIOD);
    check(last_low_len == PERIOD*GS_DIV + 1, "R10", "enabled length", last_low_len,
          PERIOD*GS_DIV + 1);
    wait_fall();
    check(last_hi_len < PERIOD*GS_DIV/4, "R11", "dark length", last_hi_len, PERIOD*GS_DIV/4);
    check(last_lat_bits == FRAME, "R4", "bits per frame", last_lat_bits, FRAME);
  endtask

  task automatic t_order();
    for (int i = 0; i < NUM_CH; i++) begin
      expv[i] = 12'((i * 12'h135 + 7) & 12'hfff);
      if (i == 0) expv[i] = 12'hfff;
      if (i == 1) expv[i] = 12'h000;
      if (i == NUM_CH-1) expv[i] = 12'ha5c;
      wr(i, int'(expv[i]));
    end
    wait_load();
    check_frame("R5");
    check(rx_lat[FRAME-1] == expv[NUM_CH-1][11], "R5", "first bit is msb of last index",
          int'(rx_lat[FRAME-1]), int'(expv[NUM_CH-1][11]));
    check(rx_lat[11:0] == 12'hfff, "R5", "index 0 sent last", int'(rx_lat[11:0]), 12'hfff);
    check(last_gs_edges == PERIOD, "R3", "second period edges", last_gs_edges, PERIOD);
    check(last_low_len == PERIOD*GS_DIV + 1, "R10", "second enabled length", last_low_len,
          PERIOD*GS_DIV + 1);
  endtask

  task automatic t_resend();
    wait_load();
    check(last_lat_bits == FRAME, "R4", "resend bit count", last_lat_bits, FRAME);
    check_frame("R4");
  endtask

  task automatic t_snapshot();
    wait_rise();
    repeat (10) @(negedge clk);
    wr(5, 12'h3c3);
    wait_load();
    check_frame("R8");
    expv[5] = 12'h3c3;
    wait_load();
    check_frame("R8");
  endtask

  task automatic t_oor();
    wr(NUM_CH + 8, 12'h777);
    wr(2*NUM_CH - 1, 12'h111);
    wait_load();
    check(rx_lat[12*8 +: 12] == expv[8], "R9", "alias of index 40",
          int'(rx_lat[12*8 +: 12]), int'(expv[8]));
    check(rx_lat[12*(NUM_CH-1) +: 12] == expv[NUM_CH-1], "R9", "alias of index 63",
          int'(rx_lat[12*(NUM_CH-1) +: 12]), int'(expv[NUM_CH-1]));
    check_frame("R9");
  endtask

  task automatic t_protocol();
    check(v6 == 0, "R6", "data change while serial clock high", v6, 0);
    check(v7 == 0, "R7", "load strobe timing violations", v7, 0);
    check(v3 == 0, "R3", "pwm clk while dark", v3, 0);
  endtask

  initial begin
    for (int i = 0; i < NUM_CH; i++) expv[i] = 12'h000;
    t_reset();
    t_boot();
    t_period();
    t_order();
    t_resend();
    t_snapshot();
    t_oor();
    t_protocol();
    if (timeout) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=1 expected=0");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule